// File: doc/BRIEF.md
# MESI Snooping Line Controller

This block keeps a small direct-mapped private cache coherent with its peers on a shared, atomic snooping bus. Every line carries a tag, one data word and a four-state coherence tag (Modified, Exclusive, Shared, Invalid). Local processor reads and writes are served on hits in the cycle they are presented. Misses, writes to shared lines and dirty evictions are turned into bus requests toward an arbiter. Transactions that other caches place on the bus arrive on a snoop port. They are answered combinationally in the same cycle with a shared indication and, when the line is owned, the line's data. The line's state is updated at the following clock edge.

The controller FSM has three named states. CS_IDLE accepts or stalls the processor. CS_REQ holds a bus request and re-derives the operation every cycle from the current line. CS_WAIT waits for the bus to report completion. The transitions are: CS_IDLE to CS_REQ on a processor request that cannot complete locally; CS_REQ to CS_WAIT on grant; CS_WAIT to CS_IDLE on done. After a fill or upgrade, the held processor request is retried in CS_IDLE and completes there as an ordinary hit. A parameter, SHARED_SUPPLIES (default 0), selects whether a Shared line drives its data when it snoops a bus read.

Top module: `mesi_cache_ctrl`

## Requirements
- R1: Line states use the 2-bit code Invalid=00, Shared=01, Exclusive=10, Modified=11. After reset every line is Invalid, so no snoop gets a shared or flush response.
- R2: A read miss raises bus_req with bus_op=01 (read) at the missing address. At bus_done the line fills from bus_rdata and becomes Shared if bus_shared was high, Exclusive otherwise. The read then acknowledges with the filled data.
- R3: A write to a line that is not present raises bus_op=10 (read-exclusive). At bus_done the line fills and becomes Modified. The write is then merged byte by byte under cpu_be.
- R4: A write hit on an Exclusive line acknowledges in the cycle it is presented, makes no bus request, and leaves the line Modified.
- R5: A write hit on a Shared line raises bus_op=11 (upgrade). bus_rdata is ignored at completion. The line becomes Modified, keeps its own data, and then takes the write.
- R6: Read hits in Modified, Exclusive or Shared, and write hits in Modified, acknowledge in the cycle presented with no bus request and no state change.
- R7: A snooped read (snp_op=01) hitting an Exclusive or Modified line asserts snp_shared and snp_flush with the line data on snp_data. The line becomes Shared.
- R8: A snooped read-exclusive (snp_op=10) hitting an Exclusive or Modified line asserts snp_flush with the line data. The line becomes Invalid.
- R9: A snooped read-exclusive or upgrade (11) hitting a Shared line invalidates it without flushing. Snoops to an Invalid line or a different tag, and snooped write-backs (00), give no response and change nothing.
- R10: A snooped read hitting a Shared line asserts snp_shared and leaves the line Shared. snp_flush is asserted only when SHARED_SUPPLIES is 1.
- R11: A miss whose index holds a Modified line of another tag first issues bus_op=00 (write-back) with the victim address and data, invalidates the victim, and then issues the miss request. A clean victim is dropped with no write-back.
- R12: One processor request is outstanding. cpu_ack never rises while a bus transaction is pending. A processor access stalls for a cycle in which a snoop targets the same index.
- R13: If a pending upgrade's line is invalidated by a snoop before grant, the request is reissued as read-exclusive (10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ack |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | ADDR_W | Word address: low IDX_W bits index, rest tag |
| cpu_wdata | input | DATA_W | Write data |
| cpu_be | input | DATA_W/8 | Byte enables for writes |
| cpu_ack | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Line data (read result) while cpu_ack |
| bus_req | output | 1 | Bus request toward the arbiter |
| bus_op | output | 2 | 00 write-back, 01 read, 10 read-exclusive, 11 upgrade |
| bus_addr | output | ADDR_W | Address of the requested transaction |
| bus_wdata | output | DATA_W | Victim data for write-back |
| bus_gnt | input | 1 | Grant; transaction starts this cycle |
| bus_done | input | 1 | Transaction complete; fill fields valid |
| bus_shared | input | 1 | Another cache holds the line (read only) |
| bus_rdata | input | DATA_W | Fill data from a peer or memory |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 2 | Snooped operation, same code as bus_op |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped line (reads) |
| snp_flush | output | 1 | This cache drives the line's data |
| snp_data | output | DATA_W | Flushed data |

## Verification
The assertions check, on every cycle, the state each completed fill leaves behind (Shared or Exclusive by the shared report, Modified after read-exclusive). They also check that an acknowledged write to an Exclusive line leaves it Modified with no request, that owned lines snooped by a read drop to Shared, and that Invalid lines stay silent and unchanged under snoop. Only the bench's scenarios can show the longer orderings. These are the write-back before refill with its victim address and data, the conversion of a lost upgrade into read-exclusive, the same-index stall, and that data written before an upgrade survives it. The scenarios also show that state changes made by snoops appear later as the right bus operation.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_SHD = 2'b01,
        LS_EXC = 2'b10,
        LS_MOD = 2'b11
    } line_st_e;

    typedef enum logic [1:0] {
        BOP_WB  = 2'b00,
        BOP_RD  = 2'b01,
        BOP_RDX = 2'b10,
        BOP_UPG = 2'b11
    } bus_op_e;

    typedef enum logic [1:0] {
        CS_IDLE = 2'b00,
        CS_REQ  = 2'b01,
        CS_WAIT = 2'b10
    } ctl_st_e;

endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
    import mesi_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [IDX_W-1:0]               a_idx,
    output logic [TAG_W-1:0]               a_tag,
    output logic [DATA_W-1:0]              a_data,
    output line_st_e                       a_st,
    input  logic [IDX_W-1:0]               b_idx,
    output logic [TAG_W-1:0]               b_tag,
    output logic [DATA_W-1:0]              b_data,
    output line_st_e                       b_st,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [TAG_W-1:0]               wr_tag,
    input  logic [DATA_W-1:0]              wr_data,
    input  line_st_e                       wr_st,
    input  logic                           su_en,
    input  logic [IDX_W-1:0]               su_idx,
    input  line_st_e                       su_st,
    output logic [(1<<IDX_W)-1:0][1:0]     st_vec
);

    localparam int NL = 1 << IDX_W;

    logic [TAG_W-1:0]  tag_q [NL];
    logic [DATA_W-1:0] dat_q [NL];
    line_st_e          st_q  [NL];

    for (genvar i = 0; i < NL; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[i] <= LS_INV;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                st_q[i] <= wr_st;
            end else if (su_en && su_idx == IDX_W'(i)) begin
                st_q[i] <= su_st;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(i)) begin
                tag_q[i] <= wr_tag;
                dat_q[i] <= wr_data;
            end
        end

        assign st_vec[i] = st_q[i];
    end

    assign a_tag  = tag_q[a_idx];
    assign a_data = dat_q[a_idx];
    assign a_st   = st_q[a_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_data = dat_q[b_idx];
    assign b_st   = st_q[b_idx];

    AST_RESET_INVALID: assert property (@(posedge clk)
        $rose(rst_n) |-> (st_vec == '0)); // R1

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
    import mesi_pkg::*;
#(
    parameter int TAG_W           = 6,
    parameter int DATA_W          = 32,
    parameter bit SHARED_SUPPLIES = 1'b0
) (
    input  logic              snp_valid,
    input  bus_op_e           snp_op,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic [TAG_W-1:0]  line_tag,
    input  line_st_e          line_st,
    input  logic [DATA_W-1:0] line_data,
    output logic              resp_shared,
    output logic              resp_flush,
    output logic [DATA_W-1:0] resp_data,
    output logic              upd_en,
    output line_st_e          upd_st
);

    logic hit;
    logic owned;

    assign hit   = snp_valid && (line_st != LS_INV) && (line_tag == snp_tag);
    assign owned = (line_st == LS_EXC) || (line_st == LS_MOD);

    always_comb begin
        resp_shared = 1'b0;
        resp_flush  = 1'b0;
        upd_en      = 1'b0;
        upd_st      = line_st;
        if (hit) begin
            unique case (snp_op)
                BOP_RD: begin
                    resp_shared = 1'b1;
                    resp_flush  = owned || SHARED_SUPPLIES;
                    upd_en      = owned;
                    upd_st      = LS_SHD;
                end
                BOP_RDX: begin
                    resp_flush  = owned;
                    upd_en      = 1'b1;
                    upd_st      = LS_INV;
                end
                BOP_UPG: begin
                    upd_en      = 1'b1;
                    upd_st      = LS_INV;
                end
                BOP_WB: begin
                    upd_en      = 1'b0;
                end
            endcase
        end
    end

    assign resp_data = resp_flush ? line_data : '0;

endmodule

// File: rtl/mesi_cache_ctrl.sv
module mesi_cache_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W          = 8,
    parameter int DATA_W          = 32,
    parameter int IDX_W           = 2,
    parameter bit SHARED_SUPPLIES = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_req,
    input  logic                  cpu_we,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [DATA_W-1:0]     cpu_wdata,
    input  logic [DATA_W/8-1:0]   cpu_be,
    output logic                  cpu_ack,
    output logic [DATA_W-1:0]     cpu_rdata,
    output logic                  bus_req,
    output logic [1:0]            bus_op,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_gnt,
    input  logic                  bus_done,
    input  logic                  bus_shared,
    input  logic [DATA_W-1:0]     bus_rdata,
    input  logic                  snp_valid,
    input  logic [1:0]            snp_op,
    input  logic [ADDR_W-1:0]     snp_addr,
    output logic                  snp_shared,
    output logic                  snp_flush,
    output logic [DATA_W-1:0]     snp_data
);

    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int BE_W  = DATA_W / 8;
    localparam int NL    = 1 << IDX_W;

    ctl_st_e              cs_q, cs_d;
    bus_op_e              txn_q;
    logic [ADDR_W-1:0]    txn_addr_q;

    logic [IDX_W-1:0]     cpu_idx, snp_idx, fill_idx;
    logic [TAG_W-1:0]     cpu_tag, snp_tag, fill_tag;
    logic [TAG_W-1:0]     a_tag, b_tag;
    logic [DATA_W-1:0]    a_data, b_data, merged;
    line_st_e             a_st, b_st;
    logic [NL-1:0][1:0]   st_vec;

    logic                 tag_hit, proc_ok, snp_conflict, need_wb;
    bus_op_e              req_op;

    logic                 wr_en;
    logic [TAG_W-1:0]     wr_tag;
    logic [DATA_W-1:0]    wr_data;
    line_st_e             wr_st;
    logic                 su_en;
    line_st_e             su_st;

    assign cpu_idx  = cpu_addr[IDX_W-1:0];
    assign cpu_tag  = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_idx  = snp_addr[IDX_W-1:0];
    assign snp_tag  = snp_addr[ADDR_W-1:IDX_W];
    assign fill_idx = txn_addr_q[IDX_W-1:0];
    assign fill_tag = txn_addr_q[ADDR_W-1:IDX_W];

    mesi_line_array #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_lines (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_idx  (cpu_idx),
        .a_tag  (a_tag),
        .a_data (a_data),
        .a_st   (a_st),
        .b_idx  (snp_idx),
        .b_tag  (b_tag),
        .b_data (b_data),
        .b_st   (b_st),
        .wr_en  (wr_en),
        .wr_idx (cs_q == CS_WAIT ? fill_idx : cpu_idx),
        .wr_tag (wr_tag),
        .wr_data(wr_data),
        .wr_st  (wr_st),
        .su_en  (su_en),
        .su_idx (snp_idx),
        .su_st  (su_st),
        .st_vec (st_vec)
    );

    mesi_snoop_resp #(
        .TAG_W          (TAG_W),
        .DATA_W         (DATA_W),
        .SHARED_SUPPLIES(SHARED_SUPPLIES)
    ) u_snoop (
        .snp_valid  (snp_valid),
        .snp_op     (bus_op_e'(snp_op)),
        .snp_tag    (snp_tag),
        .line_tag   (b_tag),
        .line_st    (b_st),
        .line_data  (b_data),
        .resp_shared(snp_shared),
        .resp_flush (snp_flush),
        .resp_data  (snp_data),
        .upd_en     (su_en),
        .upd_st     (su_st)
    );

    // Byte-wise merge of the processor write into the current line word.
    for (genvar b = 0; b < BE_W; b++) begin : g_merge
        assign merged[b*8 +: 8] = cpu_be[b] ? cpu_wdata[b*8 +: 8] : a_data[b*8 +: 8];
    end

    assign tag_hit      = (a_st != LS_INV) && (a_tag == cpu_tag);
    assign proc_ok      = tag_hit && (!cpu_we || a_st == LS_EXC || a_st == LS_MOD);
    assign snp_conflict = snp_valid && (snp_idx == cpu_idx);
    assign need_wb      = (a_st == LS_MOD) && (a_tag != cpu_tag);

    always_comb begin
        if (need_wb)                                    req_op = BOP_WB;
        else if (tag_hit && a_st == LS_SHD && cpu_we)   req_op = BOP_UPG;
        else if (cpu_we)                                req_op = BOP_RDX;
        else                                            req_op = BOP_RD;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q       <= CS_IDLE;
            txn_q      <= BOP_RD;
            txn_addr_q <= '0;
        end else begin
            cs_q <= cs_d;
            if (cs_q == CS_REQ && bus_gnt) begin
                txn_q      <= req_op;
                txn_addr_q <= bus_addr;
            end
        end
    end

    // Next-state logic
    always_comb begin
        cs_d = cs_q;
        unique case (cs_q)
            CS_IDLE: if (cpu_req && !proc_ok && !snp_conflict) cs_d = CS_REQ;
            CS_REQ:  if (bus_gnt)  cs_d = CS_WAIT;
            CS_WAIT: if (bus_done) cs_d = CS_IDLE;
            default: cs_d = CS_IDLE;
        endcase
    end

    // Outputs and line-array write port
    always_comb begin
        cpu_ack   = (cs_q == CS_IDLE) && cpu_req && proc_ok && !snp_conflict;
        cpu_rdata = a_data;
        bus_req   = (cs_q == CS_REQ);
        bus_op    = req_op;
        bus_addr  = need_wb ? {a_tag, cpu_idx} : cpu_addr;
        bus_wdata = a_data;

        wr_en   = 1'b0;
        wr_tag  = a_tag;
        wr_data = a_data;
        wr_st   = a_st;
        if (cs_q == CS_WAIT && bus_done) begin
            unique case (txn_q)
                BOP_WB: begin
                    wr_en = 1'b1;
                    wr_st = LS_INV;
                end
                BOP_UPG: begin
                    wr_en = tag_hit && (a_st == LS_SHD);
                    wr_st = LS_MOD;
                end
                BOP_RD: begin
                    wr_en   = 1'b1;
                    wr_tag  = fill_tag;
                    wr_data = bus_rdata;
                    wr_st   = bus_shared ? LS_SHD : LS_EXC;
                end
                BOP_RDX: begin
                    wr_en   = 1'b1;
                    wr_tag  = fill_tag;
                    wr_data = bus_rdata;
                    wr_st   = LS_MOD;
                end
            endcase
        end else if (cpu_ack && cpu_we) begin
            wr_en   = 1'b1;
            wr_data = merged;
            wr_st   = LS_MOD;
        end
    end

    AST_RD_FILL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q == CS_WAIT && bus_done && txn_q == BOP_RD)
        |=> (st_vec[$past(fill_idx)] == ($past(bus_shared) ? LS_SHD : LS_EXC))); // R2

    AST_RDX_ENDS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q == CS_WAIT && bus_done && txn_q == BOP_RDX)
        |=> (st_vec[$past(fill_idx)] == LS_MOD)); // R3

    AST_SILENT_E2M: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_we && a_st == LS_EXC)
        |=> (st_vec[$past(cpu_idx)] == LS_MOD && !bus_req)); // R4

    AST_SNP_RD_TO_SHD: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_op == BOP_RD && b_tag == snp_tag && cs_q != CS_WAIT
         && (b_st == LS_EXC || b_st == LS_MOD))
        |=> (st_vec[$past(snp_idx)] == LS_SHD)); // R7

    AST_SNP_INV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && b_st == LS_INV) |-> (!snp_flush && !snp_shared)); // R9

    AST_SNP_INV_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && b_st == LS_INV && cs_q != CS_WAIT)
        |=> (st_vec[$past(snp_idx)] == LS_INV)); // R9

    AST_NO_ACK_IN_TXN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req || cs_q == CS_WAIT) |-> !cpu_ack); // R12

endmodule

// File: tb/mesi_cache_ctrl_tb_top.sv
`timescale 1ns/1ps
module mesi_cache_ctrl_tb_top;

    localparam logic [1:0] OP_WB  = 2'b00;
    localparam logic [1:0] OP_RD  = 2'b01;
    localparam logic [1:0] OP_RDX = 2'b10;
    localparam logic [1:0] OP_UPG = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic        bus_req;
    logic [1:0]  bus_op;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_gnt = 1'b0, bus_done = 1'b0, bus_shared = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_op = '0;
    logic [7:0]  snp_addr = '0;
    logic        snp_shared, snp_flush;
    logic [31:0] snp_data;

    int n_chk = 0;
    int n_bad = 0;

    logic [1:0]  ops     [4];
    logic [7:0]  op_addr [4];
    logic [31:0] op_wdata[4];

    always #4 clk = ~clk;

    mesi_cache_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_shared(bus_shared), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_data(snp_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One processor access; grants every bus request and completes it the next cycle.
    task automatic access(input logic we, input logic [7:0] a, input logic [31:0] wd,
                          input logic [3:0] be, input logic shr, input logic [31:0] fill,
                          output logic [31:0] rd, output int nops, output int lat);
        int stage = 0;
        nops = 0; lat = -1; rd = '0;
        @(posedge clk); #1;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
        for (int cyc = 0; cyc < 60; cyc++) begin
            if (cyc > 0) begin @(posedge clk); #1; end
            bus_gnt = 1'b0; bus_done = 1'b0;
            if (stage == 1) begin
                bus_done = 1'b1; bus_rdata = fill; bus_shared = shr; stage = 0;
            end
            #2;
            if (cpu_ack) begin rd = cpu_rdata; lat = cyc; break; end
            if (bus_req) begin
                if (nops < 4) begin
                    ops[nops] = bus_op; op_addr[nops] = bus_addr; op_wdata[nops] = bus_wdata;
                end
                nops++;
                bus_gnt = 1'b1; stage = 1;
            end
        end
        @(posedge clk); #1;
        cpu_req = 1'b0; bus_done = 1'b0; bus_gnt = 1'b0;
    endtask

    task automatic snoop(input logic [1:0] op, input logic [7:0] a,
                         output logic sh, output logic fl, output logic [31:0] d);
        @(posedge clk); #1;
        snp_valid = 1'b1; snp_op = op; snp_addr = a;
        #2;
        sh = snp_shared; fl = snp_flush; d = snp_data;
        @(posedge clk); #1;
        snp_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic sh, fl; logic [31:0] d;
        @(posedge clk); #3;
        chk("R1", "bus_req idle", 32'(bus_req), 32'd0);
        chk("R1", "cpu_ack idle", 32'(cpu_ack), 32'd0);
        for (int i = 0; i < 4; i++) begin
            snoop(OP_RD, 8'(i), sh, fl, d);
            chk("R1", "reset snoop shared", 32'(sh), 32'd0);
            chk("R1", "reset snoop flush", 32'(fl), 32'd0);
        end
    endtask

    task automatic t_read_miss_and_hits;
        logic [31:0] rd; int n, lat;
        access(1'b0, 8'h10, '0, 4'h0, 1'b0, 32'hA1A2A3A4, rd, n, lat);
        chk("R2", "read miss op count", 32'(n), 32'd1);
        chk("R2", "read miss op", 32'(ops[0]), 32'(OP_RD));
        chk("R2", "read miss addr", 32'(op_addr[0]), 32'h10);
        chk("R2", "read miss data", rd, 32'hA1A2A3A4);
        chk("R12", "miss latency", 32'(lat), 32'd3);
        access(1'b0, 8'h10, '0, 4'h0, 1'b0, 32'h0, rd, n, lat);
        chk("R6", "E read hit ops", 32'(n), 32'd0);
        chk("R6", "E read hit latency", 32'(lat), 32'd0);
        chk("R6", "E read hit data", rd, 32'hA1A2A3A4);
        access(1'b1, 8'h10, 32'h0000BEEF, 4'b0011, 1'b0, 32'h0, rd, n, lat);
        chk("R4", "E write hit ops", 32'(n), 32'd0);
        chk("R4", "E write hit latency", 32'(lat), 32'd0);
        access(1'b0, 8'h10, '0, 4'h0, 1'b0, 32'h0, rd, n, lat);
        chk("R6", "M read hit ops", 32'(n), 32'd0);
        chk("R4", "merged data", rd, 32'hA1A2BEEF);
        access(1'b1, 8'h10, 32'h11000000, 4'b1000, 1'b0, 32'h0, rd, n, lat);
        chk("R6", "M write hit ops", 32'(n), 32'd0);
        access(1'b0, 8'h10, '0, 4'h0, 1'b0, 32'h0, rd, n, lat);
        chk("R6", "M write hit data", rd, 32'h11A2BEEF);
    endtask

    task automatic t_snoop_read_then_upgrade;
        logic sh, fl; logic [31:0] d, rd; int n, lat;
        snoop(OP_RD, 8'h10, sh, fl, d);
        chk("R7", "M snoop rd shared", 32'(sh), 32'd1);
        chk("R7", "M snoop rd flush", 32'(fl), 32'd1);
        chk("R7", "M snoop rd data", d, 32'h11A2BEEF);
        access(1'b1, 8'h10, 32'h000000CC, 4'b0001, 1'b0, 32'hDEADDEAD, rd, n, lat);
        chk("R5", "S write ops", 32'(n), 32'd1);
        chk("R5", "S write op", 32'(ops[0]), 32'(OP_UPG));
        chk("R5", "S write addr", 32'(op_addr[0]), 32'h10);
        access(1'b0, 8'h10, '0, 4'h0, 1'b0, 32'h0, rd, n, lat);
        chk("R5", "upgrade kept own data", rd, 32'h11A2BECC);
        chk("R5", "after upgrade read is hit", 32'(n), 32'd0);
    endtask

    task automatic t_snoop_rdx_owned;
        logic sh, fl; logic [31:0] d, rd; int n, lat;
        snoop(OP_RDX, 8'h10, sh, fl, d);
        chk("R8", "M snoop rdx flush", 32'(fl), 32'd1);
        chk("R8", "M snoop rdx data", d, 32'h11A2BECC);
        chk("R8", "M snoop rdx shared", 32'(sh), 32'd0);
        access(1'b0, 8'h10, '0, 4'h0, 1'b1, 32'h55667788, rd, n, lat);
        chk("R8", "line invalid after rdx", 32'(ops[0]), 32'(OP_RD));
        chk("R2", "shared fill data", rd, 32'h55667788);
    endtask

    task automatic t_snoop_on_shared;
        logic sh, fl; logic [31:0] d, rd; int n, lat;
        snoop(OP_RD, 8'h10, sh, fl, d);
        chk("R10", "S snoop rd shared", 32'(sh), 32'd1);
        chk("R10", "S snoop rd flush (param 0)", 32'(fl), 32'd0);
        access(1'b0, 8'h10, '0, 4'h0, 1'b0, 32'h0, rd, n, lat);
        chk("R10", "S kept after snoop rd", 32'(n), 32'd0);
        chk("R2", "S read hit data", rd, 32'h55667788);
        snoop(OP_RD, 8'h20, sh, fl, d);
        chk("R9", "tag miss snoop shared", 32'(sh), 32'd0);
        chk("R9", "tag miss snoop flush", 32'(fl), 32'd0);
        snoop(OP_WB, 8'h10, sh, fl, d);
        chk("R9", "snooped write-back silent", 32'(sh | fl), 32'd0);
        access(1'b0, 8'h10, '0, 4'h0, 1'b0, 32'h0, rd, n, lat);
        chk("R9", "line kept after ignored snoops", 32'(n), 32'd0);
    endtask

    task automatic t_invalidate_shared;
        logic sh, fl; logic [31:0] d, rd; int n, lat;
        snoop(OP_UPG, 8'h10, sh, fl, d);
        chk("R9", "S snoop upg flush", 32'(fl), 32'd0);
        access(1'b0, 8'h10, '0, 4'h0, 1'b0, 32'h01020304, rd, n, lat);
        chk("R9", "invalid after snoop upg", 32'(ops[0]), 32'(OP_RD));
        snoop(OP_RD, 8'h10, sh, fl, d);
        chk("R7", "E snoop rd flush", 32'(fl), 32'd1);
        chk("R7", "E snoop rd data", d, 32'h01020304);
        snoop(OP_RDX, 8'h10, sh, fl, d);
        chk("R9", "S snoop rdx flush", 32'(fl), 32'd0);
        access(1'b0, 8'h10, '0, 4'h0, 1'b0, 32'h0BADF00D, rd, n, lat);
        chk("R9", "invalid after snoop rdx", 32'(n), 32'd1);
        chk("R9", "refill op", 32'(ops[0]), 32'(OP_RD));
    endtask

    task automatic t_write_miss;
        logic [31:0] rd; int n, lat;
        access(1'b1, 8'h05, 32'hCAFE0000, 4'b1100, 1'b0, 32'h12345678, rd, n, lat);
        chk("R3", "write miss ops", 32'(n), 32'd1);
        chk("R3", "write miss op", 32'(ops[0]), 32'(OP_RDX));
        chk("R3", "write miss addr", 32'(op_addr[0]), 32'h05);
        access(1'b0, 8'h05, '0, 4'h0, 1'b0, 32'h0, rd, n, lat);
        chk("R3", "write miss merged", rd, 32'hCAFE5678);
        chk("R3", "line modified (hit)", 32'(n), 32'd0);
    endtask

    task automatic t_eviction;
        logic sh, fl; logic [31:0] d, rd; int n, lat;
        access(1'b0, 8'h09, '0, 4'h0, 1'b0, 32'h9999AAAA, rd, n, lat);
        chk("R11", "dirty evict ops", 32'(n), 32'd2);
        chk("R11", "first op write-back", 32'(ops[0]), 32'(OP_WB));
        chk("R11", "victim addr", 32'(op_addr[0]), 32'h05);
        chk("R11", "victim data", op_wdata[0], 32'hCAFE5678);
        chk("R11", "second op read", 32'(ops[1]), 32'(OP_RD));
        chk("R11", "second op addr", 32'(op_addr[1]), 32'h09);
        chk("R11", "new data", rd, 32'h9999AAAA);
        chk("R11", "evict latency", 32'(lat), 32'd6);
        snoop(OP_RD, 8'h05, sh, fl, d);
        chk("R11", "victim gone", 32'(sh | fl), 32'd0);
        access(1'b0, 8'h0D, '0, 4'h0, 1'b0, 32'h0D0D0D0D, rd, n, lat);
        chk("R11", "clean victim no write-back", 32'(n), 32'd1);
        chk("R11", "clean victim op", 32'(ops[0]), 32'(OP_RD));
    endtask

    task automatic t_lost_upgrade;
        logic [31:0] rd; int n, lat;
        access(1'b0, 8'h02, '0, 4'h0, 1'b1, 32'h22222222, rd, n, lat);
        @(posedge clk); #1;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h02; cpu_wdata = 32'h33; cpu_be = 4'b0001;
        @(posedge clk); #3;
        chk("R5", "pending upgrade req", 32'(bus_req), 32'd1);
        chk("R5", "pending upgrade op", 32'(bus_op), 32'(OP_UPG));
        @(posedge clk); #1;
        snp_valid = 1'b1; snp_op = OP_UPG; snp_addr = 8'h02;
        @(posedge clk); #1;
        snp_valid = 1'b0;
        #2;
        chk("R13", "reissued op", 32'(bus_op), 32'(OP_RDX));
        chk("R13", "still requesting", 32'(bus_req), 32'd1);
        bus_gnt = 1'b1;
        @(posedge clk); #1;
        bus_gnt = 1'b0; bus_done = 1'b1; bus_rdata = 32'h44444444; bus_shared = 1'b0;
        #2;
        chk("R12", "no ack during txn", 32'(cpu_ack), 32'd0);
        @(posedge clk); #1;
        bus_done = 1'b0;
        #2;
        chk("R13", "write acked after refill", 32'(cpu_ack), 32'd1);
        @(posedge clk); #1;
        cpu_req = 1'b0;
        access(1'b0, 8'h02, '0, 4'h0, 1'b0, 32'h0, rd, n, lat);
        chk("R13", "data after refill and write", rd, 32'h44444433);
    endtask

    task automatic t_index_conflict;
        logic [31:0] rd; int n, lat;
        access(1'b0, 8'h03, '0, 4'h0, 1'b0, 32'h03030303, rd, n, lat);
        @(posedge clk); #1;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h03;
        snp_valid = 1'b1; snp_op = OP_RD; snp_addr = 8'h03;
        #2;
        chk("R12", "stall on same-index snoop", 32'(cpu_ack), 32'd0);
        chk("R7", "flush during stall", 32'(snp_flush), 32'd1);
        @(posedge clk); #1;
        snp_valid = 1'b0;
        #2;
        chk("R12", "ack after snoop", 32'(cpu_ack), 32'd1);
        chk("R12", "data after stall", cpu_rdata, 32'h03030303);
        chk("R12", "no bus use on stall", 32'(bus_req), 32'd0);
        @(posedge clk); #1;
        cpu_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_read_miss_and_hits();
        t_snoop_read_then_upgrade();
        t_snoop_rdx_owned();
        t_snoop_on_shared();
        t_invalidate_shared();
        t_write_miss();
        t_eviction();
        t_lost_upgrade();
        t_index_conflict();
        repeat (2) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule